// File: doc/BRIEF.md
# Shared Prescaler Tick Generator

This block produces the count-enable pulses for a five-channel timer, all from one reference clock. Two 8-bit prescale counters run in the reference domain. Channels 0 and 1 share the first, and channels 2, 3 and 4 share the second. Each channel then passes its prescaler's ticks through its own power-of-two divider.

Each tick output is a one-cycle enable for the channel's down-counter. No derived clocks are made. The two configuration words come in through write strobes with their data. The block holds them itself, with their reset values, and any write restarts every counter so that the new rates start from a known phase.

Top module: `pwm_tick_gen`

## Requirements
- R1: After reset, config word 0 holds 0x0101 and config word 1 holds 0. Every channel then ticks on every second cycle. The first tick falls in the second cycle after reset release.
- R2: Channels 0 and 1 take their prescale field from bits [7:0] of word 0. Channels 2, 3 and 4 take theirs from bits [15:8]. The two fields are independent.
- R3: A prescale field value P gives a prescale ratio of P+1 reference cycles per prescaler tick, for every P from 0 to 255.
- R4: Channel x takes its divider field n from bits [4x+3:4x] of word 1. For n from 0 to 4 the divide ratio is 2^n prescaler ticks.
- R5: A divider field value above 4 (5 to 15) divides by 16.
- R6: Each tick_o bit is high for one reference cycle once every (P+1)*2^n cycles, and low in the cycles between. When the ratio is 1 it stays high.
- R7: A write to either word restarts both prescalers and all five dividers. With the write taken at clock edge k, a channel's first tick is in the cycle after edge k + (P+1)*2^n - 1, computed with the new values.
- R8: Both words can be written at the same edge. Both take their new values and one common restart follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg0_we_i | input | 1 | Write strobe for word 0 (prescale fields) |
| cfg0_wdata_i | input | 16 | Data for word 0: [7:0] for channels 0-1, [15:8] for channels 2-4 |
| cfg1_we_i | input | 1 | Write strobe for word 1 (divider fields) |
| cfg1_wdata_i | input | 20 | Data for word 1: 4 bits per channel, channel x at [4x+3:4x] |
| tick_o | output | 5 | One-cycle count enables, bit x for channel x |

## Verification
Each tick is decoded straight from the prescale and divide counters. A write at edge k therefore shows as restarted counters right after that edge. The first tick of a channel is due (P+1)*2^n - 1 edges later, and after that one comes every (P+1)*2^n cycles.

The bench keeps its own count of edges since the last write or reset. It drives inputs and compares every channel at the falling edge, so each comparison sees the state settled by the edge just before it. The expected value is true only when that count plus one is a multiple of the channel's period.

// File: rtl/pwm_tick_pkg.sv
package pwm_tick_pkg;

  // Clamp a divider field to the largest supported shift.
  function automatic int unsigned clamp_shift(input int unsigned field, input int unsigned max_shift);
    return (field > max_shift) ? max_shift : field;
  endfunction

endpackage

// File: rtl/tick_prescaler.sv
module tick_prescaler #(
  parameter int unsigned PRE_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic [PRE_W-1:0] limit_i,
  output logic             tick_o
);

  logic [PRE_W-1:0] cnt_q;

  assign tick_o = (cnt_q == limit_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clr_i)   cnt_q <= '0;
    else if (tick_o)  cnt_q <= '0;
    else              cnt_q <= cnt_q + 1'b1;
  end

  p_cnt_in_range_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= limit_i);

  p_restart_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_q == '0));

endmodule

// File: rtl/tick_divider.sv
module tick_divider #(
  parameter int unsigned MAX_SHIFT = 4,
  localparam int unsigned SH_W     = $clog2(MAX_SHIFT + 1)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clr_i,
  input  logic            pre_tick_i,
  input  logic [SH_W-1:0] shift_i,
  output logic            tick_o
);

  logic [MAX_SHIFT-1:0] cnt_q;
  logic [MAX_SHIFT-1:0] mask;

  assign mask   = ~({MAX_SHIFT{1'b1}} << shift_i);
  assign tick_o = pre_tick_i && (cnt_q == mask);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         cnt_q <= '0;
    else if (clr_i)      cnt_q <= '0;
    else if (pre_tick_i) cnt_q <= (cnt_q == mask) ? '0 : cnt_q + 1'b1;
  end

  p_dcnt_range_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q & ~mask) == '0);

  p_single_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && shift_i != '0 && !clr_i) |=> !tick_o);

  p_restart_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_q == '0));

endmodule

// File: rtl/pwm_tick_gen.sv
module pwm_tick_gen #(
  parameter int unsigned NUM_CH    = 5,
  parameter int unsigned SPLIT     = 2,  // channels below SPLIT use prescaler 0
  parameter int unsigned PRE_W     = 8,
  parameter int unsigned DIV_FW    = 4,
  parameter int unsigned MAX_SHIFT = 4,
  localparam int unsigned NUM_PRE  = 2,
  localparam int unsigned CFG0_W   = NUM_PRE * PRE_W,
  localparam int unsigned CFG1_W   = NUM_CH * DIV_FW,
  localparam int unsigned SH_W     = $clog2(MAX_SHIFT + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg0_we_i,
  input  logic [CFG0_W-1:0] cfg0_wdata_i,
  input  logic              cfg1_we_i,
  input  logic [CFG1_W-1:0] cfg1_wdata_i,
  output logic [NUM_CH-1:0] tick_o
);
  import pwm_tick_pkg::*;

  localparam logic [CFG0_W-1:0] CFG0_RST = {NUM_PRE{PRE_W'(1)}};

  logic [CFG0_W-1:0]  cfg0_q;
  logic [CFG1_W-1:0]  cfg1_q;
  logic               restart;
  logic [NUM_PRE-1:0] pre_tick;

  assign restart = cfg0_we_i | cfg1_we_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg0_q <= CFG0_RST;
      cfg1_q <= '0;
    end else begin
      if (cfg0_we_i) cfg0_q <= cfg0_wdata_i;
      if (cfg1_we_i) cfg1_q <= cfg1_wdata_i;
    end
  end

  for (genvar p = 0; p < NUM_PRE; p++) begin : g_pre
    tick_prescaler #(.PRE_W(PRE_W)) i_pre (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .clr_i   (restart),
      .limit_i (cfg0_q[p*PRE_W +: PRE_W]),
      .tick_o  (pre_tick[p])
    );
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    localparam int unsigned PI = (c < SPLIT) ? 0 : 1;
    logic [SH_W-1:0] shift;

    assign shift = SH_W'(clamp_shift(int'(cfg1_q[c*DIV_FW +: DIV_FW]), MAX_SHIFT));

    tick_divider #(.MAX_SHIFT(MAX_SHIFT)) i_div (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .clr_i      (restart),
      .pre_tick_i (pre_tick[PI]),
      .shift_i    (shift),
      .tick_o     (tick_o[c])
    );

    p_tick_needs_pre_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tick_o[c] |-> pre_tick[PI]);
  end

endmodule

// File: tb/test_pwm_tick_gen.sv
module test_pwm_tick_gen;
  localparam int NUM_CH = 5;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg0_we_i = 1'b0;
  logic [15:0] cfg0_wdata_i = '0;
  logic        cfg1_we_i = 1'b0;
  logic [19:0] cfg1_wdata_i = '0;
  logic [4:0]  tick_o;

  pwm_tick_gen i_pwm_tick_gen (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cfg0_we_i    (cfg0_we_i),
    .cfg0_wdata_i (cfg0_wdata_i),
    .cfg1_we_i    (cfg1_we_i),
    .cfg1_wdata_i (cfg1_wdata_i),
    .tick_o       (tick_o)
  );

  always #2ns clk_i = ~clk_i;

  int    errors = 0;
  int    checks = 0;
  bit    done = 0;
  string req_s = "R1";

  logic [15:0] m_cfg0 = 16'h0101;
  logic [19:0] m_cfg1 = '0;
  int          since = 0;

  function automatic int period_of(int ch, logic [15:0] c0, logic [19:0] c1);
    int p = (ch < 2) ? int'(c0[7:0]) : int'(c0[15:8]);
    int n = int'(c1[ch*4 +: 4]);
    if (n > 4) n = 4;
    return (p + 1) * (1 << n);
  endfunction

  function automatic int max_period();
    int m = 1;
    for (int ch = 0; ch < NUM_CH; ch++)
      if (period_of(ch, m_cfg0, m_cfg1) > m) m = period_of(ch, m_cfg0, m_cfg1);
    return m;
  endfunction

  task automatic check_all();
    for (int ch = 0; ch < NUM_CH; ch++) begin
      bit exp = ((since + 1) % period_of(ch, m_cfg0, m_cfg1)) == 0;
      checks++;
      if (tick_o[ch] !== exp) begin
        errors++;
        $display("FAIL %s ch%0d cycle %0d: tick=%b expected=%b", req_s, ch, since, tick_o[ch], exp);
      end
    end
  endtask

  // Called at a falling edge; advances one edge and checks at the next falling edge.
  task automatic step(bit w0, logic [15:0] d0, bit w1, logic [19:0] d1);
    cfg0_we_i = w0; cfg0_wdata_i = d0;
    cfg1_we_i = w1; cfg1_wdata_i = d1;
    @(posedge clk_i);
    if (w0) m_cfg0 = d0;
    if (w1) m_cfg1 = d1;
    if (w0 || w1) since = 0; else since++;
    @(negedge clk_i);
    cfg0_we_i = 1'b0;
    cfg1_we_i = 1'b0;
    check_all();
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(1'b0, '0, 1'b0, '0);
  endtask

  task automatic cfg(logic [15:0] d0, logic [19:0] d1, int extra);
    step(1'b1, d0, 1'b1, d1);
    idle(extra);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    since = 0;
    check_all();                         // R1 reset state
    idle(12);

    req_s = "R2";                        // split prescalers
    cfg(16'h0502, 20'h00000, 40);
    req_s = "R3";                        // extreme prescale values
    cfg(16'hFF00, 20'h00000, 600);
    req_s = "R4";                        // each divider field 0..4
    cfg(16'h0101, 20'h43210, 80);
    req_s = "R5";                        // fields above 4
    cfg(16'h0000, 20'hF9654, 60);
    req_s = "R6";                        // ratio 1 stays high
    cfg(16'h0000, 20'h00000, 8);

    req_s = "R7";                        // restart from word 0 only, mid period
    cfg(16'h0303, 20'h11111, 5);
    step(1'b1, 16'h0204, 1'b0, '0);
    idle(50);
    step(1'b0, '0, 1'b1, 20'h01234);     // restart from word 1 only
    idle(120);

    req_s = "R8";
    cfg(16'h0706, 20'h32103, 150);

    req_s = "R6";
    void'($urandom(32'd1234));
    for (int k = 0; k < 15; k++) begin
      logic [15:0] d0 = 16'($urandom());
      logic [19:0] d1 = 20'($urandom());
      int len;
      step(1'b1, d0, 1'b1, d1);
      len = 2 * max_period() + 5;
      if (len > 4000) len = 4000;
      idle(len);
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1600us;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule